// File: doc/BRIEF.md
# PCM Frame Sync Period Checker

This block serves one serial PCM link running on a 2.048 MHz bit clock. It samples the incoming frame sync and serial data on a clock edge chosen by configuration, rising or falling. From those samples it keeps a bit-cell index (0 to 255) within each 256-cell frame and a frame index within a sync period. The sync period is set to one frame, 12 frames or 24 frames. Serial-to-parallel logic further along uses these counters, together with a frame-start strobe and a data-valid flag, to pick channels out of the stream.

After reset the block is unaligned. The first sync pulse sets the counters to bit 0 of frame 0. From then on, every sync pulse is checked against the position the counters predict. A pulse anywhere other than the first cell of the first frame of a period sets a sticky error flag, and the counters realign so that the pulse becomes the new frame start. A missing pulse is not an error: the counters keep running and wrap. In T1 mode only the first 193 cells of each frame hold data, and the valid flag is low for the rest.

Top module: `pcm_sync_checker`

## Requirements
- R1: While reset is asserted and right after it is released, aligned, sts_err, frame_start and data_valid are 0, and bit_idx and frame_idx are 0.
- R2: Before alignment, the counters stay at 0. The first sampled sync pulse makes the next state aligned, with bit_idx 0 and frame_idx 0, and does not set sts_err.
- R3: Once aligned and with no sync pulse sampled, bit_idx counts up by one on each clock and wraps from 255 to 0. frame_start is high exactly when aligned and bit_idx is 0.
- R4: frame_idx goes up by one when bit_idx wraps, and returns to 0 after the last frame of the period. cfg_period encodes the period: 0 means 1 frame, 1 means 12 frames, 2 means 24 frames, and 3 means 1 frame.
- R5: A sync pulse sampled in the cell that follows bit_idx 255 of the last frame of the period is expected, and leaves sts_err unchanged.
- R6: A sync pulse sampled at any other position while aligned sets sts_err. The next state has bit_idx 0 and frame_idx 0.
- R7: When expected sync pulses are missing, the counters free-run, aligned stays 1, and sts_err stays 0.
- R8: When cfg_t1 is 1, data_valid is 0 for bit_idx 193 to 255 and 1 for bit_idx 0 to 192 while aligned. When cfg_t1 is 0, data_valid equals aligned.
- R9: With cfg_fall_edge 0, the inputs are captured on the rising edge, and input held during clock cycle k is reflected in the outputs after the rising edge ending cycle k+1. With cfg_fall_edge 1, they are captured on the falling edge, and the outputs reflect the input after the rising edge ending cycle k.
- R10: A high sts_clr clears sts_err on the next clock. If an error is detected in the same cycle, sts_err stays 1.
- R11: data_out shows the sampled data bit of the cell that bit_idx currently names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fall_edge | input | 1 | 1: sample sync and data on the falling edge |
| cfg_t1 | input | 1 | 1: T1 framing with 193 valid cells |
| cfg_period | input | 2 | Sync period select (0/3: 1 frame, 1: 12, 2: 24) |
| sync_in | input | 1 | Frame sync pulse, one cell wide |
| data_in | input | 1 | Serial data |
| sts_clr | input | 1 | Write-one-to-clear pulse for sts_err |
| bit_idx | output | 8 | Bit-cell index within the frame |
| frame_idx | output | 5 | Frame index within the sync period |
| frame_start | output | 1 | High in the first cell of each frame |
| data_valid | output | 1 | Current cell carries payload |
| data_out | output | 1 | Sampled data of the current cell |
| aligned | output | 1 | A sync pulse has been seen since reset |
| sts_err | output | 1 | Sticky misplaced-sync flag |

## Verification
The assertions take for granted that cfg_period, cfg_t1 and cfg_fall_edge change only while reset is held. Without that, the frame index could briefly sit above the last frame of a shorter period. The stimulus changes configuration only inside a reset sequence and drives every input just after a rising edge. Those values are then stable at both the falling edge and the next rising edge, whichever one the sampler uses. Sync pulses are one cell wide. They are placed at expected positions, left out for whole frames, or dropped at arbitrary cells, including the cell where a clear pulse lands.

// File: rtl/pcm_sync_pkg.sv
package pcm_sync_pkg;

    typedef enum logic [1:0] {
        PER_ONE   = 2'd0,
        PER_SHORT = 2'd1,
        PER_LONG  = 2'd2,
        PER_ALT   = 2'd3
    } sync_period_e;

    // Index of the last frame inside one sync period.
    function automatic int last_frame(input logic [1:0] sel,
                                      input int short_len,
                                      input int long_len);
        int r;
        case (sync_period_e'(sel))
            PER_SHORT: r = short_len - 1;
            PER_LONG:  r = long_len - 1;
            default:   r = 0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pcm_edge_sampler.sv
module pcm_edge_sampler #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_sel,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] dout
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic rise_d, rise_q;
        logic fall_d, fall_q;

        always_comb begin
            rise_d = din[g];
            fall_d = din[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rise_q <= 1'b0;
            else        rise_q <= rise_d;
        end

        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) fall_q <= 1'b0;
            else        fall_q <= fall_d;
        end

        assign dout[g] = fall_sel ? fall_q : rise_q;
    end

endmodule

// File: rtl/pcm_frame_tracker.sv
module pcm_frame_tracker
    import pcm_sync_pkg::*;
#(
    parameter int CELLS    = 256,
    parameter int SF_SHORT = 12,
    parameter int SF_LONG  = 24,
    localparam int BW = $clog2(CELLS),
    localparam int FW = $clog2(SF_LONG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    period_sel,
    input  logic          smp_sync,
    input  logic          smp_data,
    output logic          aligned,
    output logic [BW-1:0] bit_idx,
    output logic [FW-1:0] frm_idx,
    output logic          cell_data,
    output logic          err_set
);

    typedef struct packed {
        logic          aligned;
        logic [BW-1:0] bit_idx;
        logic [FW-1:0] frm_idx;
        logic          data;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic [FW-1:0] last_frm;
    logic          wrap;
    logic [BW-1:0] step_bit;
    logic [FW-1:0] step_frm;
    logic          on_time;

    always_comb begin
        last_frm = FW'(last_frame(period_sel, SF_SHORT, SF_LONG));
        wrap     = (st_q.bit_idx == BW'(CELLS - 1));
        step_bit = wrap ? '0 : st_q.bit_idx + 1'b1;
        if (wrap)
            step_frm = (st_q.frm_idx >= last_frm) ? '0 : st_q.frm_idx + 1'b1;
        else
            step_frm = st_q.frm_idx;
        on_time  = wrap && (step_frm == '0);

        st_d      = st_q;
        st_d.data = smp_data;
        err_set   = 1'b0;
        if (!st_q.aligned) begin
            if (smp_sync) begin
                st_d.aligned = 1'b1;
                st_d.bit_idx = '0;
                st_d.frm_idx = '0;
            end
        end else if (smp_sync) begin
            err_set      = !on_time;
            st_d.bit_idx = '0;
            st_d.frm_idx = '0;
        end else begin
            st_d.bit_idx = step_bit;
            st_d.frm_idx = step_frm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign aligned   = st_q.aligned;
    assign bit_idx   = st_q.bit_idx;
    assign frm_idx   = st_q.frm_idx;
    assign cell_data = st_q.data;

    AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.aligned && !smp_sync && st_q.bit_idx != BW'(CELLS - 1))
        |=> (st_q.bit_idx == $past(st_q.bit_idx) + 1'b1)); // R3
    AST_BIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.aligned && !smp_sync && st_q.bit_idx == BW'(CELLS - 1))
        |=> (st_q.bit_idx == '0)); // R3
    AST_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        smp_sync |=> (st_q.aligned && st_q.bit_idx == '0 && st_q.frm_idx == '0)); // R6
    AST_FRM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.aligned |-> (st_q.frm_idx <= last_frm)); // R4
    AST_FIRST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.aligned |-> !err_set); // R2

endmodule

// File: rtl/pcm_sticky_flag.sv
module pcm_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = (st_q.flag && !clr) || set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr) |=> st_q.flag); // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && clr && !set) |=> !st_q.flag); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> st_q.flag); // R6

endmodule

// File: rtl/pcm_sync_checker.sv
module pcm_sync_checker
    import pcm_sync_pkg::*;
#(
    parameter int CELLS    = 256,
    parameter int T1_CELLS = 193,
    parameter int SF_SHORT = 12,
    parameter int SF_LONG  = 24,
    localparam int BW = $clog2(CELLS),
    localparam int FW = $clog2(SF_LONG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fall_edge,
    input  logic          cfg_t1,
    input  logic [1:0]    cfg_period,
    input  logic          sync_in,
    input  logic          data_in,
    input  logic          sts_clr,
    output logic [BW-1:0] bit_idx,
    output logic [FW-1:0] frame_idx,
    output logic          frame_start,
    output logic          data_valid,
    output logic          data_out,
    output logic          aligned,
    output logic          sts_err
);

    logic [1:0] smp;
    logic       err_set;

    pcm_edge_sampler #(.LANES(2)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_sel (cfg_fall_edge),
        .din      ({data_in, sync_in}),
        .dout     (smp)
    );

    pcm_frame_tracker #(
        .CELLS    (CELLS),
        .SF_SHORT (SF_SHORT),
        .SF_LONG  (SF_LONG)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_sel (cfg_period),
        .smp_sync   (smp[0]),
        .smp_data   (smp[1]),
        .aligned    (aligned),
        .bit_idx    (bit_idx),
        .frm_idx    (frame_idx),
        .cell_data  (data_out),
        .err_set    (err_set)
    );

    pcm_sticky_flag u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .clr   (sts_clr),
        .flag  (sts_err)
    );

    always_comb begin
        frame_start = aligned && (bit_idx == '0);
        data_valid  = aligned && (!cfg_t1 || (bit_idx < BW'(T1_CELLS)));
    end

    AST_UNALIGNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |-> (!sts_err && !data_valid && !frame_start)); // R2

endmodule

// File: tb/pcm_sync_checker_test.sv
module pcm_sync_checker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_fall_edge = 1'b0;
    logic       cfg_t1 = 1'b0;
    logic [1:0] cfg_period = 2'd0;
    logic       sync_in = 1'b0;
    logic       data_in = 1'b0;
    logic       sts_clr = 1'b0;
    logic [7:0] bit_idx;
    logic [4:0] frame_idx;
    logic       frame_start, data_valid, data_out, aligned, sts_err;

    always #4 clk = ~clk;

    pcm_sync_checker uut (
        .clk(clk), .rst_n(rst_n), .cfg_fall_edge(cfg_fall_edge), .cfg_t1(cfg_t1),
        .cfg_period(cfg_period), .sync_in(sync_in), .data_in(data_in),
        .sts_clr(sts_clr), .bit_idx(bit_idx), .frame_idx(frame_idx),
        .frame_start(frame_start), .data_valid(data_valid), .data_out(data_out),
        .aligned(aligned), .sts_err(sts_err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int m_al, m_bit, m_frm, m_err, m_dat;
    bit h_sync[$];
    bit h_data[$];
    bit clr_cur;
    int ph;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int plen();
        case (cfg_period)
            2'd1: return 12;
            2'd2: return 24;
            default: return 1;
        endcase
    endfunction

    task automatic model_step();
        bit s, d;
        int nb, nf, ne;
        int last = h_sync.size() - 1;
        int k = cfg_fall_edge ? last : last - 1;
        s = h_sync[k];
        d = h_data[k];
        ne = 0;
        m_dat = d;
        if (m_al == 0) begin
            if (s) begin m_al = 1; m_bit = 0; m_frm = 0; end
        end else begin
            nb = (m_bit + 1) % 256;
            nf = (nb == 0) ? ((m_frm + 1 >= plen()) ? 0 : m_frm + 1) : m_frm;
            if (s) begin
                if (!(nb == 0 && nf == 0)) ne = 1;
                m_bit = 0; m_frm = 0;
            end else begin
                m_bit = nb; m_frm = nf;
            end
        end
        m_err = ((m_err != 0) && !clr_cur) || (ne != 0) ? 1 : 0;
    endtask

    task automatic compare_all();
        int ex_fs = (m_al != 0 && m_bit == 0) ? 1 : 0;
        int ex_dv = (m_al != 0 && (!cfg_t1 || m_bit < 193)) ? 1 : 0;
        check(aligned == m_al[0], "R2 aligned", aligned, m_al);
        check(bit_idx == m_bit[7:0], "R3 bit_idx", bit_idx, m_bit);
        check(frame_start == ex_fs[0], "R3 frame_start", frame_start, ex_fs);
        check(frame_idx == m_frm[4:0], "R4 frame_idx", frame_idx, m_frm);
        check(data_valid == ex_dv[0], "R8 data_valid", data_valid, ex_dv);
        check(data_out == m_dat[0], "R11 data_out", data_out, m_dat);
        check(sts_err == m_err[0], "R6 sts_err", sts_err, m_err);
    endtask

    task automatic cyc(input bit s, input bit c);
        bit d = 1'($urandom_range(0, 1));
        @(posedge clk);
        model_step();
        #1;
        sync_in = s; data_in = d; sts_clr = c;
        h_sync.push_back(s); h_data.push_back(d);
        if (h_sync.size() > 4) begin void'(h_sync.pop_front()); void'(h_data.pop_front()); end
        clr_cur = c;
        ph = s ? 1 : ph + 1;
        #2;
        compare_all();
    endtask

    task automatic do_reset(input bit fall, input bit t1, input logic [1:0] per);
        @(posedge clk); #1;
        rst_n = 1'b0; sync_in = 0; data_in = 0; sts_clr = 0;
        cfg_fall_edge = fall; cfg_t1 = t1; cfg_period = per;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
        m_al = 0; m_bit = 0; m_frm = 0; m_err = 0; m_dat = 0;
        h_sync = {0, 0}; h_data = {0, 0}; clr_cur = 0; ph = 0;
        #2;
        // R1 reset state
        check(!aligned && !sts_err && !frame_start && !data_valid, "R1 flags", {aligned, sts_err, frame_start, data_valid}, 0);
        check(bit_idx == 0 && frame_idx == 0, "R1 counters", {bit_idx, frame_idx}, 0);
    endtask

    // drive n cycles, with sync at expected points if pulses
    task automatic run(input int n, input bit pulses);
        for (int i = 0; i < n; i++) begin
            bit s = pulses && ((ph % (256 * plen())) == 0);
            cyc(s, 1'b0);
        end
    endtask

    task automatic first_align(input bit fall);
        repeat (10) cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        // R9: falling edge shows alignment one cycle after the pulse
        check(aligned == fall, "R9 latency", aligned, fall);
        cyc(1'b0, 1'b0);
        check(aligned == 1'b1 && sts_err == 1'b0, "R2 first pulse", {aligned, sts_err}, 2);
    endtask

    initial begin
        // E1, every frame, rising edge
        do_reset(1'b0, 1'b0, 2'd0);
        first_align(1'b0);
        run(800, 1'b1);
        check(sts_err == 0, "R5 expected pulses", sts_err, 0);
        run(700, 1'b0);
        check(aligned == 1 && sts_err == 0, "R7 missing pulses", {aligned, sts_err}, 2);
        // misplaced pulse
        run(37, 1'b0);
        cyc(1'b1, 1'b0);
        run(3, 1'b0);
        check(sts_err == 1, "R6 misplaced", sts_err, 1);
        cyc(1'b0, 1'b1);
        run(2, 1'b0);
        check(sts_err == 0, "R10 clear", sts_err, 0);
        // error and clear meet at the core (rising: clr one cycle later)
        run(90, 1'b0);
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        run(2, 1'b0);
        check(sts_err == 1, "R10 set wins", sts_err, 1);
        run(600, 1'b1);

        // 12-frame superframe, falling edge, T1
        do_reset(1'b1, 1'b1, 2'd1);
        first_align(1'b1);
        run(256 * 12 * 2 + 50, 1'b1);
        check(sts_err == 0, "R5 superframe 12", sts_err, 0);
        // pulse at a frame start that is not a superframe start
        run(256 * 12 - (ph % (256 * 12)) + 256, 1'b0);
        cyc(1'b1, 1'b0);
        run(2, 1'b0);
        check(sts_err == 1, "R6 wrong frame", sts_err, 1);
        cyc(1'b1, 1'b1); // falling: error and clear hit the same edge
        run(2, 1'b0);
        check(sts_err == 1, "R10 set wins fall", sts_err, 1);
        run(400, 1'b0);

        // 24-frame superframe, rising, E1
        do_reset(1'b0, 1'b0, 2'd2);
        first_align(1'b0);
        run(256 * 24 * 2 + 300, 1'b1);
        check(sts_err == 0, "R5 superframe 24", sts_err, 0);

        // code 3 behaves as one frame, T1
        do_reset(1'b1, 1'b1, 2'd3);
        first_align(1'b1);
        run(1200, 1'b1);
        check(sts_err == 0, "R4 code3 period", sts_err, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule